// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller for a dual-slope integrating analog-to-digital converter. It steps the external analog section through four phases in a fixed cycle: offset cancel (auto-zero), signal integration, reference de-integration and integrator discharge. For each phase it raises exactly one switch-control output. The only analog feedback it reads is a single comparator bit that reports the polarity of the integrator output.

All phase timing comes from a prescaled timebase tick. The host writes an 8-bit load value and marks the end of the write with a one-cycle strobe. That value sets one length, and both the auto-zero and the integrate phases use it. The de-integrate phase counts ticks until the comparator flips. That count is the conversion result, and it is bounded by a limit of twice the integrate length. A sign flag and an overrange flag are captured with the result. All three are published together, with a one-cycle valid pulse, at the moment the sequencer returns to auto-zero. The active-low end-of-conversion output stays low for the whole auto-zero phase, so it can serve as a data-ready interrupt. A synchronous reset holds the sequencer in auto-zero for as long as it is asserted.

Top module: `dslope_seq`

## Requirements
- R1: The phases follow the order auto-zero, integrate, de-integrate, integrator-zero, then auto-zero again, and this repeats without a gap. Exactly one of `sw_az`, `sw_int`, `sw_dint`, `sw_iz` is high at any time.
- R2: All phase timing advances on a tick that occurs once every `CLK_DIV` clock cycles. Every phase therefore lasts a whole number of `CLK_DIV` cycles.
- R3: Auto-zero and integrate each last U × `UNIT_TICKS` ticks. U is 256 minus the load value, and a load value of 0 gives U = 256.
- R4: `sign` equals the value of `cmp_in` sampled on the last tick of the integrate phase.
- R5: De-integrate ends on the first tick at which `cmp_in` differs from the captured sign. `result` is the number of earlier de-integrate ticks, and `ovr` is 0.
- R6: If no crossing is seen within twice the integrate tick count, de-integrate ends on that tick with `ovr` = 1 and `result` equal to twice the integrate tick count. A crossing seen on the limit tick itself still counts as a normal result.
- R7: Integrator-zero ends on the first tick at which `cmp_in` differs from its value at phase entry, or after `IZ_TICKS` ticks, whichever comes first.
- R8: While `rst` is high, the sequencer sits in auto-zero and the prescaler is held. The load value, `result`, `sign`, `ovr` and `data_valid` are cleared. After release, auto-zero runs its full length.
- R9: `eoc_n` is low exactly while the sequencer is in auto-zero.
- R10: `result`, `sign` and `ovr` change only in the cycle in which `data_valid` is high. That pulse lasts one cycle and coincides with the move from integrator-zero to auto-zero.
- R11: A `load_stb` pulse stores `load_val`, abandons any conversion in progress without publishing it, and restarts auto-zero from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset; holds the sequencer in auto-zero |
| load_val | input | LOAD_W | Phase-length load value |
| load_stb | input | 1 | One-cycle end-of-write strobe; latches `load_val` and restarts |
| cmp_in | input | 1 | Comparator bit: 1 means the integrator output is above zero |
| sw_az | output | 1 | Auto-zero switch control |
| sw_int | output | 1 | Input-integrate switch control |
| sw_dint | output | 1 | Reference de-integrate switch control |
| sw_iz | output | 1 | Integrator-zero switch control |
| eoc_n | output | 1 | Active-low end of conversion |
| data_valid | output | 1 | One-cycle pulse when new data is published |
| result | output | RES_W | De-integrate tick count |
| sign | output | 1 | Input polarity captured at the end of integrate |
| ovr | output | 1 | Overrange flag |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot phase register and the legal successor of each phase. Others are also checked every cycle: the de-integrate counter stays below its limit, reset parks the sequencer, the published data is stable between valid pulses and the pulse lasts a single cycle, and the sign is captured on entry to de-integrate. Only the bench scenarios can show the exact phase lengths, because those depend on the load value. The same holds for the result and overrange values produced by crossings placed before, at and beyond the limit, for early exit from integrator-zero, for aborting a conversion with a new load, and for the cleared load value after reset.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  localparam int PH_AZ   = 0;
  localparam int PH_INT  = 1;
  localparam int PH_DINT = 2;
  localparam int PH_IZ   = 3;
  localparam int N_PHASE = 4;

  typedef logic [N_PHASE-1:0] phase_vec_t;

  function automatic phase_vec_t phase_bit(input int idx);
    phase_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic clr,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(CLK_DIV);
      localparam logic [W-1:0] LAST = W'(CLK_DIV - 1);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (clr)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);

      // R2: the divider never leaves its range, and ticks never come back to back
      p_div_range_r2: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= LAST);
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (clr)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int LOAD_W     = 8,
  parameter int UNIT_TICKS = 256,
  parameter int IZ_TICKS   = 256,
  parameter int RES_W      = LOAD_W + 1 + $clog2(UNIT_TICKS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LOAD_W-1:0] load_val,
  input  logic             load_stb,
  input  logic             cmp_in,
  output phase_vec_t       phase,
  output logic             publish,
  output logic [RES_W-1:0] pend_cnt,
  output logic             pend_ovr,
  output logic             sign_cap
);
  localparam int UW = LOAD_W + 1;
  localparam logic [UW-1:0] FULL = {1'b1, {LOAD_W{1'b0}}};
  localparam logic [RES_W-1:0] IZ_LAST = RES_W'(IZ_TICKS - 1);

  phase_vec_t        ph_q;
  logic [LOAD_W-1:0] ld_q;
  logic [RES_W-1:0]  tcnt_q;
  logic              iz_ref_q;

  logic [UW-1:0]     units;
  logic [RES_W-1:0]  len;
  logic [RES_W-1:0]  lim;
  logic              az_int_last;
  logic              crossed;
  logic              at_limit;
  logic              iz_exit;

  // phase length from the load value; 0 wraps to the full range
  assign units       = (ld_q == '0) ? FULL : (FULL - {1'b0, ld_q});
  assign len         = RES_W'(units) * RES_W'(UNIT_TICKS);
  assign lim         = len << 1;
  assign az_int_last = (tcnt_q == len - 1'b1);
  assign crossed     = (cmp_in != sign_cap);
  assign at_limit    = (tcnt_q == lim - 1'b1);
  assign iz_exit     = (cmp_in != iz_ref_q) || (tcnt_q == IZ_LAST);
  assign publish     = !rst && !load_stb && tick && ph_q[PH_IZ] && iz_exit;
  assign phase       = ph_q;

  always_ff @(posedge clk) begin
    if (rst)           ld_q <= '0;
    else if (load_stb) ld_q <= load_val;
  end

  always_ff @(posedge clk) begin
    if (rst || load_stb) begin
      ph_q   <= phase_bit(PH_AZ);
      tcnt_q <= '0;
      if (rst) begin
        sign_cap <= 1'b0;
        pend_cnt <= '0;
        pend_ovr <= 1'b0;
        iz_ref_q <= 1'b0;
      end
    end else if (tick) begin
      if (ph_q[PH_AZ]) begin
        if (az_int_last) begin
          ph_q   <= phase_bit(PH_INT);
          tcnt_q <= '0;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end else if (ph_q[PH_INT]) begin
        if (az_int_last) begin
          ph_q     <= phase_bit(PH_DINT);
          tcnt_q   <= '0;
          sign_cap <= cmp_in;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end else if (ph_q[PH_DINT]) begin
        if (crossed) begin
          ph_q     <= phase_bit(PH_IZ);
          pend_cnt <= tcnt_q;
          pend_ovr <= 1'b0;
          tcnt_q   <= '0;
          iz_ref_q <= cmp_in;
        end else if (at_limit) begin
          ph_q     <= phase_bit(PH_IZ);
          pend_cnt <= lim;
          pend_ovr <= 1'b1;
          tcnt_q   <= '0;
          iz_ref_q <= cmp_in;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end else begin
        if (iz_exit) begin
          ph_q   <= phase_bit(PH_AZ);
          tcnt_q <= '0;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  // R1: exactly one phase active
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(ph_q) == 1);
  // R1: legal successors (a load strobe may always force auto-zero)
  p_after_az_r1: assert property (@(posedge clk) disable iff (rst)
    ph_q[PH_AZ] |=> (ph_q[PH_AZ] || ph_q[PH_INT]));
  p_after_int_r1: assert property (@(posedge clk) disable iff (rst)
    ph_q[PH_INT] |=> (ph_q[PH_INT] || ph_q[PH_DINT] || $past(load_stb)));
  p_after_dint_r1: assert property (@(posedge clk) disable iff (rst)
    ph_q[PH_DINT] |=> (ph_q[PH_DINT] || ph_q[PH_IZ] || $past(load_stb)));
  p_after_iz_r1: assert property (@(posedge clk) disable iff (rst)
    ph_q[PH_IZ] |=> (ph_q[PH_IZ] || ph_q[PH_AZ]));
  // R4: sign is the comparator value on the edge that enters de-integrate
  p_sign_cap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(ph_q[PH_DINT]) && !$past(load_stb)) |-> (sign_cap == $past(cmp_in)));
  // R6: the de-integrate count never reaches the limit while running
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (rst || load_stb)
    ph_q[PH_DINT] |-> (tcnt_q < lim));
  // R8: reset parks the sequencer at the start of auto-zero
  p_hold_az_r8: assert property (@(posedge clk)
    rst |=> (ph_q[PH_AZ] && tcnt_q == '0));
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             publish,
  input  logic [RES_W-1:0] cnt_in,
  input  logic             ovr_in,
  input  logic             sign_in,
  output logic [RES_W-1:0] result_q,
  output logic             ovr_q,
  output logic             sign_q,
  output logic             valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      ovr_q    <= 1'b0;
      sign_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= publish;
      if (publish) begin
        result_q <= cnt_in;
        ovr_q    <= ovr_in;
        sign_q   <= sign_in;
      end
    end
  end

  // R10: published data changes only with the valid pulse
  p_data_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> ($stable(result_q) && $stable(ovr_q) && $stable(sign_q)));
  // R10: the valid pulse lasts a single cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int LOAD_W     = 8,
  parameter int CLK_DIV    = 4,
  parameter int UNIT_TICKS = 256,
  parameter int IZ_TICKS   = 256,
  parameter int RES_W      = LOAD_W + 1 + $clog2(UNIT_TICKS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              load_stb,
  input  logic              cmp_in,
  output logic              sw_az,
  output logic              sw_int,
  output logic              sw_dint,
  output logic              sw_iz,
  output logic              eoc_n,
  output logic              data_valid,
  output logic [RES_W-1:0]  result,
  output logic              sign,
  output logic              ovr
);
  logic             tick;
  phase_vec_t       phase;
  logic             publish;
  logic [RES_W-1:0] pend_cnt;
  logic             pend_ovr;
  logic             sign_cap;

  dslope_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk  (clk),
    .clr  (rst | load_stb),
    .tick (tick)
  );

  dslope_fsm #(
    .LOAD_W    (LOAD_W),
    .UNIT_TICKS(UNIT_TICKS),
    .IZ_TICKS  (IZ_TICKS),
    .RES_W     (RES_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load_val (load_val),
    .load_stb (load_stb),
    .cmp_in   (cmp_in),
    .phase    (phase),
    .publish  (publish),
    .pend_cnt (pend_cnt),
    .pend_ovr (pend_ovr),
    .sign_cap (sign_cap)
  );

  dslope_result #(.RES_W(RES_W)) u_res (
    .clk      (clk),
    .rst      (rst),
    .publish  (publish),
    .cnt_in   (pend_cnt),
    .ovr_in   (pend_ovr),
    .sign_in  (sign_cap),
    .result_q (result),
    .ovr_q    (ovr),
    .sign_q   (sign),
    .valid_q  (data_valid)
  );

  assign sw_az   = phase[PH_AZ];
  assign sw_int  = phase[PH_INT];
  assign sw_dint = phase[PH_DINT];
  assign sw_iz   = phase[PH_IZ];
  assign eoc_n   = ~phase[PH_AZ];

  // R9: end of conversion tracks auto-zero, and data arrives only on its entry
  p_valid_on_az_r10: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> (sw_az && !eoc_n));
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
  localparam int LW   = 8;
  localparam int DIV  = 4;
  localparam int UT   = 4;
  localparam int IZT  = 8;
  localparam int RW   = LW + 1 + $clog2(UT) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] load_val = '0;
  logic          load_stb = 1'b0;
  logic          cmp = 1'b0;
  logic sw_az, sw_int, sw_dint, sw_iz, eoc_n, data_valid, sign, ovr;
  logic [RW-1:0] result;

  int total = 0;
  int bad = 0;
  int eoc_err = 0;
  int oh_err = 0;

  always #2 clk = ~clk;

  dslope_seq #(.LOAD_W(LW), .CLK_DIV(DIV), .UNIT_TICKS(UT), .IZ_TICKS(IZT)) u_dut (
    .clk(clk), .rst(rst), .load_val(load_val), .load_stb(load_stb), .cmp_in(cmp),
    .sw_az(sw_az), .sw_int(sw_int), .sw_dint(sw_dint), .sw_iz(sw_iz),
    .eoc_n(eoc_n), .data_valid(data_valid), .result(result), .sign(sign), .ovr(ovr)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int units_of(input int ld);
    return (ld == 0) ? 256 : 256 - ld;
  endfunction

  function automatic logic ph(input int i);
    case (i)
      0: return sw_az;
      1: return sw_int;
      2: return sw_dint;
      default: return sw_iz;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    if ((sw_az + sw_int + sw_dint + sw_iz) != 1) oh_err++;
    if (eoc_n != !sw_az) eoc_err++;
  endtask

  task automatic count_while(input int i, output int n);
    n = 0;
    while (ph(i)) begin step(); n++; end
  endtask

  task automatic finish_run();
    chk("R1 one-hot phase outputs", oh_err, 0);
    chk("R9 eoc_n follows auto-zero", eoc_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one full conversion: load, crossing after k ticks, iz toggle after t ticks
  task automatic run_conv(input int ld, input bit s, input int k, input int t);
    int n, len, lim, dexp, iexp;
    logic [RW-1:0] rsave;
    len = units_of(ld) * UT;
    lim = 2 * len;
    load_val = LW'(ld); load_stb = 1'b1; cmp = s;
    step();
    load_stb = 1'b0;
    count_while(0, n);
    chk("R3 R11 auto-zero length", n, len * DIV);
    count_while(1, n);
    chk("R3 integrate length", n, len * DIV);
    n = 0;
    for (int i = 0; i < k * DIV && sw_dint; i++) begin step(); n++; end
    if (sw_dint) cmp = ~s;
    while (sw_dint) begin step(); n++; end
    dexp = (k < lim) ? k + 1 : lim;
    chk("R5 R6 de-integrate length", n, dexp * DIV);
    n = 0;
    for (int i = 0; i < t * DIV && sw_iz; i++) begin step(); n++; end
    if (sw_iz) cmp = ~cmp;
    while (sw_iz) begin step(); n++; end
    iexp = (t + 1 < IZT) ? t + 1 : IZT;
    chk("R7 integrator-zero length", n, iexp * DIV);
    chk("R10 valid with auto-zero entry", {sw_az, data_valid}, 2'b11);
    chk("R5 R6 result", result, (k < lim) ? k : lim);
    chk("R6 overrange flag", ovr, (k < lim) ? 0 : 1);
    chk("R4 sign", sign, s);
    rsave = result;
    step();
    chk("R10 valid lasts one cycle", data_valid, 0);
    chk("R10 result held", result, rsave);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    int n, ld, len;
    void'($urandom(32'd5151));
    repeat (4) @(negedge clk);
    chk("R8 reset parks in auto-zero", {sw_az, sw_int, sw_dint, sw_iz, eoc_n}, 5'b10000);
    chk("R8 reset clears outputs", {data_valid, sign, ovr, result}, 0);
    rst = 1'b0;
    count_while(0, n);
    chk("R3 R8 load 0 gives 256 units", n, 256 * UT * DIV);

    // directed corners
    run_conv(255, 1'b1, 0, IZT + 1);
    run_conv(255, 1'b0, 2 * UT - 1, IZT);
    run_conv(255, 1'b1, 2 * UT, 0);
    run_conv(254, 1'b0, 4 * UT + 7, 2);
    run_conv(253, 1'b1, 100, IZT - 1);

    // R11: abort a conversion in de-integrate; no data for it is published
    load_val = 8'd254; load_stb = 1'b1; step(); load_stb = 1'b0;
    while (!sw_dint) step();
    chk("R11 no publish before restart", data_valid, 0);
    run_conv(255, 1'b0, 3, 1);

    // R8: hold in the middle of integrate
    load_val = 8'd255; load_stb = 1'b1; step(); load_stb = 1'b0;
    while (!sw_int) step();
    rst = 1'b1;
    step();
    n = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (!sw_az || eoc_n || data_valid || result != 0) n++;
    end
    chk("R8 held in auto-zero with cleared data", n, 0);
    rst = 1'b0;
    count_while(0, n);
    chk("R8 release restarts auto-zero, load cleared", n, 256 * UT * DIV);

    // constrained random
    for (int r = 0; r < 30; r++) begin
      ld  = 252 + int'($urandom % 4);
      len = units_of(ld) * UT;
      run_conv(ld, 1'($urandom % 2), int'($urandom % (2 * len + 3)),
               int'($urandom % (IZT + 2)));
    end
    finish_run();
  end
endmodule